// File: doc/BRIEF.md
# Two-Way Bus Channel Select Target

This block is a serial two-wire bus target that owns one 8-bit control byte. A controller addresses it with the fixed 7-bit pattern 1110000, writes the control byte or reads it back, and the byte decides which one of several downstream bus channels is switched through. The block runs entirely on its own system clock. It oversamples SCL and SDA through a short synchronizer, finds START and STOP conditions, shifts bits on the SCL edges and pulls SDA low through an output-enable whenever it must send a zero.

The enable outputs never follow a freshly written byte straight away. The written value waits in the register and moves to the enable outputs only when a STOP is seen. When that happens, every downstream line is idle high, so connecting a channel cannot create a false START or a truncated bit. A repeated START leaves the waiting value where it is. In a write of several bytes the final byte is the one that counts. The enable bit is bit 2, and the channel number sits in the bits below it.

Top module: `i2c_chansel_target`

## Requirements
- R1: After a START, the target drives SDA low (acknowledge) during the ninth clock only when the upper seven bits of the first byte equal 1110000. Bit 0 of that byte is the direction: 1 is read and 0 is write.
- R2: When the address does not match, the target sends no acknowledge. It also ignores all further bytes until the next START or STOP, so the control byte and the enables keep their values.
- R3: On a write, each data byte is stored into the control byte. When several bytes arrive in one transaction, the value that remains is the last one.
- R4: On a read, the target sends the control byte MSB first, with SDA changed only while SCL is low. It sends the same byte again each time the controller acknowledges. After a not-acknowledge it releases SDA (sda_oe_o = 0).
- R5: The channel enables change only in the cycle after a STOP is detected. A written byte has no effect on them before that STOP.
- R6: With bit 2 of the applied byte set, a value of 00 in bits 1:0 turns on channel 0 (ch_en_o = 01) and a value of 01 turns on channel 1 (ch_en_o = 10). Any other value in bits 1:0, or bit 2 clear, turns on no channel. Bits 7:3 are ignored. At most one enable is ever high.
- R7: Reset clears the control byte to 0x00, drives both enables low and releases SDA.
- R8: The target acknowledges every data byte written to it after a matching write address.
- R9: A repeated START restarts address reception. It does not move the waiting byte to the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low (open-drain drive) |
| ch_en_o | output | NUM_CH | One enable per downstream channel, updated at STOP |

## Verification
The bench builds the block with its default parameters: address 0x70, two channels, the enable at bit 2 and a two-flop synchronizer. With only two channels and a 2-bit selection field, the selection values 10 and 11 have no channel behind them. The bench therefore reaches the "no channel" decode path while the enable bit is set, as well as through a clear enable bit. The synchronizer latency of three system cycles is short compared with the bench controller's quarter bit time of five cycles. This makes it possible to test repeated START, readback with acknowledge and not-acknowledge, and the hold-until-STOP rule against a bit-level wired-AND bus model.

// File: rtl/chansel_pkg.sv
`timescale 1ns/1ps
package chansel_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_DATA,
      ST_WR_ACK,
      ST_RD_DATA,
      ST_RD_ACK,
      ST_SKIP
   } tgt_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic scl;
      logic sda;
   } line_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync
   import chansel_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      scl_i,
   input  logic      sda_i,
   output line_evt_t evt
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_pipe[0] <= 1'b1;
                  sda_pipe[0] <= 1'b1;
               end else begin
                  scl_pipe[0] <= scl_i;
                  sda_pipe[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_pipe[s] <= 1'b1;
                  sda_pipe[s] <= 1'b1;
               end else begin
                  scl_pipe[s] <= scl_pipe[s-1];
                  sda_pipe[s] <= sda_pipe[s-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_pipe[STAGES-1];
         sda_d <= sda_pipe[STAGES-1];
      end
   end

   always_comb begin
      evt.scl   = scl_pipe[STAGES-1];
      evt.sda   = sda_pipe[STAGES-1];
      evt.rise  = !scl_d && evt.scl;
      evt.fall  = scl_d && !evt.scl;
      evt.start = scl_d && evt.scl && sda_d && !evt.sda;
      evt.stop  = scl_d && evt.scl && !sda_d && evt.sda;
   end
endmodule

// File: rtl/i2c_target_core.sv
`timescale 1ns/1ps
module i2c_target_core
   import chansel_pkg::*;
#(
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_evt_t         evt,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] ctrl_q
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   tgt_state_e        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sr;
   logic [BYTE_W-1:0] tx_sr;
   logic              rw_q;
   logic              ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         rx_sr   <= '0;
         tx_sr   <= '0;
         rw_q    <= 1'b0;
         ack_q   <= 1'b0;
         sda_oe  <= 1'b0;
         ctrl_q  <= '0;
      end else if (evt.start) begin
         state   <= ST_ADDR;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
      end else if (evt.stop) begin
         state   <= ST_IDLE;
         sda_oe  <= 1'b0;
      end else begin
         case (state)
            ST_ADDR: begin
               if (evt.rise) begin
                  rx_sr   <= {rx_sr[BYTE_W-2:0], evt.sda};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (evt.fall && bit_cnt == LAST_BIT) begin
                  if (rx_sr[BYTE_W-1:1] == TARGET_ADDR) begin
                     state  <= ST_ADDR_ACK;
                     rw_q   <= rx_sr[0];
                     sda_oe <= 1'b1;
                  end else begin
                     state  <= ST_SKIP;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (evt.fall) begin
                  bit_cnt <= '0;
                  if (rw_q) begin
                     state  <= ST_RD_DATA;
                     tx_sr  <= ctrl_q;
                     sda_oe <= !ctrl_q[BYTE_W-1];
                  end else begin
                     state  <= ST_WR_DATA;
                     sda_oe <= 1'b0;
                  end
               end
            end
            ST_WR_DATA: begin
               if (evt.rise) begin
                  rx_sr   <= {rx_sr[BYTE_W-2:0], evt.sda};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (evt.fall && bit_cnt == LAST_BIT) begin
                  ctrl_q <= rx_sr;
                  sda_oe <= 1'b1;
                  state  <= ST_WR_ACK;
               end
            end
            ST_WR_ACK: begin
               if (evt.fall) begin
                  sda_oe  <= 1'b0;
                  bit_cnt <= '0;
                  state   <= ST_WR_DATA;
               end
            end
            ST_RD_DATA: begin
               if (evt.rise) begin
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (evt.fall) begin
                  if (bit_cnt == LAST_BIT) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RD_ACK;
                  end else begin
                     tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                     sda_oe <= !tx_sr[BYTE_W-2];
                  end
               end
            end
            ST_RD_ACK: begin
               if (evt.rise) begin
                  ack_q <= !evt.sda;
               end else if (evt.fall) begin
                  bit_cnt <= '0;
                  if (ack_q) begin
                     state  <= ST_RD_DATA;
                     tx_sr  <= ctrl_q;
                     sda_oe <= !ctrl_q[BYTE_W-1];
                  end else begin
                     state  <= ST_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R1: entering the address acknowledge needs a matching address byte
   p_addr_ack_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK && $past(state) != ST_ADDR_ACK)
         |-> ($past(rx_sr[BYTE_W-1:1]) == TARGET_ADDR));

   // R3: the control byte changes only when a data byte is acknowledged
   p_ctrl_write_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q != $past(ctrl_q)) |-> (state == ST_WR_ACK));

   // R4: the pull-down is engaged only while SCL is low
   p_oe_rises_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !evt.scl);

   // R2: in the ignore state the line is never pulled
   p_skip_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);
endmodule

// File: rtl/chansel_apply.sv
`timescale 1ns/1ps
module chansel_apply
   import chansel_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int EN_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply_i,
   input  logic [BYTE_W-1:0] ctrl_i,
   output logic [NUM_CH-1:0] ch_en
);
   localparam int SEL_W = EN_BIT;

   generate
      if (EN_BIT < 1 || EN_BIT >= BYTE_W) begin : g_bad_en
         $error("chansel_apply: EN_BIT out of range");
      end
      if (NUM_CH < 1 || NUM_CH > (1 << SEL_W)) begin : g_bad_ch
         $error("chansel_apply: NUM_CH does not fit the selection field");
      end
   endgenerate

   logic             en_q;
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else if (apply_i) begin
         en_q  <= ctrl_i[EN_BIT];
         sel_q <= ctrl_i[SEL_W-1:0];
      end
   end

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_ch
         assign ch_en[g] = en_q && (sel_q == SEL_W'(g));
      end
   endgenerate

   // R6: never more than one channel connected
   p_one_channel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_en));

   // R5: enables hold unless a STOP was just seen
   p_hold_until_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_i |=> $stable(ch_en));
endmodule

// File: rtl/i2c_chansel_target.sv
`timescale 1ns/1ps
module i2c_chansel_target
   import chansel_pkg::*;
#(
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h70,
   parameter int NUM_CH      = 2,
   parameter int EN_BIT      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic [NUM_CH-1:0] ch_en_o
);
   line_evt_t         evt;
   logic [BYTE_W-1:0] ctrl_q;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt   (evt)
   );

   i2c_target_core #(.TARGET_ADDR(TARGET_ADDR)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .sda_oe (sda_oe_o),
      .ctrl_q (ctrl_q)
   );

   chansel_apply #(.NUM_CH(NUM_CH), .EN_BIT(EN_BIT)) u_apply (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply_i (evt.stop),
      .ctrl_i  (ctrl_q),
      .ch_en   (ch_en_o)
   );
endmodule

// File: tb/i2c_chansel_target_tb_top.sv
`timescale 1ns/1ps
module i2c_chansel_target_tb_top;
   localparam int Q = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic [1:0] ch_en;
   logic       sda_bus;

   always #2.5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   i2c_chansel_target dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_bus),
      .sda_oe_o (sda_oe),
      .ch_en_o  (ch_en)
   );

   typedef struct {string req; int val;} item_t;
   item_t exp_q[$];
   int    obs_val;
   event  obs_ev;
   int    vectors = 0;
   int    fails = 0;
   bit    done = 1'b0;

   initial forever begin
      @(obs_ev);
      vectors++;
      if (exp_q.size() == 0) begin
         fails++;
         $display("FAIL unexpected result: actual=%0h expected=none", obs_val);
      end else begin
         item_t it;
         it = exp_q.pop_front();
         if (it.val != obs_val) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", it.req, obs_val, it.val);
         end
      end
   end

   task automatic chk(input string r, input int exp_v, input int got_v);
      exp_q.push_back('{r, exp_v});
      obs_val = got_v;
      ->obs_ev;
      @(negedge clk);
   endtask

   task automatic waitq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq();
      sda_m = 1'b0; waitq(); scl_m = 1'b0; waitq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; waitq(); scl_m = 1'b1; waitq();
      sda_m = 1'b1; waitq(); waitq();
   endtask

   task automatic bus_bit(input bit b, output bit seen);
      sda_m = b; waitq();
      scl_m = 1'b1; waitq();
      seen = sda_bus; waitq();
      scl_m = 1'b0; waitq();
   endtask

   task automatic send_byte(input bit [7:0] b, output bit nak);
      bit s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      bus_bit(1'b1, nak);
   endtask

   task automatic recv_byte(input bit give_ack, output bit [7:0] d);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, s);
         d[i] = s;
      end
      bus_bit(!give_ack, s);
   endtask

   task automatic read_back(input string r, input int exp_v);
      bit nak;
      bit [7:0] d;
      bus_start();
      send_byte(8'hE1, nak);
      chk(r, 0, nak);
      recv_byte(1'b0, d);
      chk(r, exp_v, d);
      chk("R4", 0, sda_oe);
      bus_stop();
   endtask

   task automatic write_one(input bit [7:0] v);
      bit nak;
      bus_start();
      send_byte(8'hE0, nak);
      chk("R1", 0, nak);
      send_byte(v, nak);
      chk("R8", 0, nak);
      bus_stop();
   endtask

   initial begin
      bit nak;
      bit [7:0] d;
      repeat (6) @(negedge clk);
      chk("R7", 0, ch_en);
      chk("R7", 0, sda_oe);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      read_back("R7", 8'h00);

      // single write, enables wait for STOP
      bus_start();
      send_byte(8'hE0, nak);
      chk("R1", 0, nak);
      send_byte(8'h04, nak);
      chk("R8", 0, nak);
      waitq();
      chk("R5", 2'b00, ch_en);
      bus_stop();
      chk("R6", 2'b01, ch_en);

      // readback with ack then nack
      bus_start();
      send_byte(8'hE1, nak);
      chk("R1", 0, nak);
      recv_byte(1'b1, d);
      chk("R4", 8'h04, d);
      recv_byte(1'b0, d);
      chk("R4", 8'h04, d);
      chk("R4", 0, sda_oe);
      bus_stop();

      // multi-byte write, last byte wins
      bus_start();
      send_byte(8'hE0, nak);
      chk("R1", 0, nak);
      send_byte(8'h00, nak);
      chk("R8", 0, nak);
      send_byte(8'hFF, nak);
      chk("R8", 0, nak);
      send_byte(8'hA5, nak);
      chk("R8", 0, nak);
      chk("R5", 2'b01, ch_en);
      bus_stop();
      chk("R3", 2'b10, ch_en);
      read_back("R3", 8'hA5);

      // mismatching address is ignored
      bus_start();
      send_byte(8'hE2, nak);
      chk("R2", 1, nak);
      send_byte(8'h04, nak);
      chk("R2", 1, nak);
      bus_stop();
      chk("R2", 2'b10, ch_en);
      read_back("R2", 8'hA5);

      // repeated START keeps the waiting byte away from the enables
      bus_start();
      send_byte(8'hE0, nak);
      chk("R1", 0, nak);
      send_byte(8'h04, nak);
      chk("R8", 0, nak);
      bus_start();
      send_byte(8'hE1, nak);
      chk("R9", 0, nak);
      recv_byte(1'b0, d);
      chk("R9", 8'h04, d);
      chk("R9", 2'b10, ch_en);
      bus_stop();
      chk("R5", 2'b01, ch_en);

      // decode corners
      write_one(8'h06);
      chk("R6", 2'b00, ch_en);
      write_one(8'h05);
      chk("R6", 2'b10, ch_en);
      write_one(8'h01);
      chk("R6", 2'b00, ch_en);
      write_one(8'h07);
      chk("R6", 2'b00, ch_en);
      write_one(8'hFC);
      chk("R6", 2'b01, ch_en);

      // reset during operation
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7", 2'b00, ch_en);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      read_back("R7", 8'h00);

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule